// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the horizontal sync, vertical sync and data-enable strobes of a raster display. It also reports the column and row of the pixel being scanned. Software sets the frame geometry through a one-cycle write port. Each axis has four intervals: sync pulse, back porch, active region and front porch. Every interval is written as its length minus one, so a value of zero gives one pixel or one line.

Each line runs sync, then back porch, then active, then front porch. The frame walks through lines in the same order. One polarity register chooses the active level of each strobe, and it also carries a data-polarity flag for a downstream pixel path. A command bit starts and stops the scan. A status bit is latched on the first clock of every vertical sync, and it drives the interrupt output only while its mask bit is set. Timing and polarity writes made during a scan are staged and take effect at the next frame boundary, so the current frame is never torn.

Top module: `vid_timing_gen`

## Requirements
- R1: Horizontal intervals are written at addresses 4 (sync), 5 (back porch), 6 (active) and 7 (front porch) as length minus one. Each line starts with the sync cycles, then back porch, active and front porch, and lasts the sum of the four lengths.
- R2: Vertical intervals are written at addresses 8 (sync), 9 (back porch), 10 (active) and 11 (front porch) as line count minus one. They follow the same order, and each step is one full line.
- R3: `de` is at its active level only when both axes are in their active interval. `pix_x` and `pix_y` count from 0 inside the active interval of their axis and read 0 everywhere else.
- R4: The polarity register is at address 1. Bit 0 controls hsync, bit 1 vsync and bit 2 de: a 1 makes that output active high and a 0 makes it active low. Bit 3 is presented on `data_pol`.
- R5: Address 0 bit 0 is the run command. Writing 1 starts a frame whose first sync cycle is the next clock. Writing 0 forces the strobes inactive and the coordinates to 0 from the next clock, and a later start begins again from the first sync cycle.
- R6: The status bit sets on the first clock of vertical sync and is visible on the following clock. `irq` is the status bit ANDed with the mask bit (address 2 bit 0), and the mask takes effect on the clock after it is written.
- R7: Writing to address 3 with bit 0 = 1 clears the status bit. Writing with bit 0 = 0 leaves it unchanged.
- R8: While running, timing and polarity writes take effect only at the next frame start. While stopped, they apply on the next clock.
- R9: After reset the block is stopped, all polarity bits are 0 (every strobe idles high), the mask and status bits are 0, and the coordinates are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | W | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per bit 0 |
| vsync | output | 1 | Vertical sync, polarity per bit 1 |
| de | output | 1 | Data enable, polarity per bit 2 |
| data_pol | output | 1 | Data polarity flag (bit 3) |
| pix_x | output | W | Column within the active area |
| pix_y | output | W | Row within the active area |
| irq | output | 1 | Masked vertical-sync interrupt |

## Verification
The bench builds the block with an 8-bit width. It programs 2/3/4/2 pixels and 1/2/3/1 lines, which gives a 77-cycle frame. At that size the bench can compare every cycle of several whole frames against a model, and both wrap points of each axis occur many times. It covers mid-frame writes that must wait for the frame boundary, and stopping and restarting mid-line. The interrupt sequence is also checked: set, masked, unmasked and cleared.

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
  parameter int W  = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          data_pol,
  output logic [W-1:0]  pix_x,
  output logic [W-1:0]  pix_y,
  output logic          irq
);
  localparam int NT = 8;
  localparam logic [1:0] S_SYNC = 2'd0, S_BACK = 2'd1, S_ACT = 2'd2, S_FRONT = 2'd3;

  logic         run_q, run_d, mask_q, stat_q;
  logic [3:0]   pol_stg, pol_q;
  logic [W-1:0] stg [NT];
  logic [W-1:0] cur [NT];
  logic [1:0]   hseg_q, vseg_q;
  logic [W-1:0] hcnt_q, vcnt_q;
  logic [W-1:0] hlen, vlen;
  logic         h_end, v_end, line_end, frame_last, first_cyc;

  wire sel_run  = wr_en && wr_addr == AW'(0);
  wire sel_pol  = wr_en && wr_addr == AW'(1);
  wire sel_mask = wr_en && wr_addr == AW'(2);
  wire sel_stat = wr_en && wr_addr == AW'(3);

  assign run_d      = sel_run ? wr_data[0] : run_q;
  assign hlen       = cur[{1'b0, hseg_q}];
  assign vlen       = cur[{1'b1, vseg_q}];
  assign h_end      = hcnt_q == hlen;
  assign v_end      = vcnt_q == vlen;
  assign line_end   = h_end && hseg_q == S_FRONT;
  assign frame_last = run_q && line_end && v_end && vseg_q == S_FRONT;
  assign first_cyc  = run_q && hseg_q == S_SYNC && vseg_q == S_SYNC &&
                      hcnt_q == '0 && vcnt_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mask_q  <= 1'b0;
      pol_stg <= '0;
      for (int i = 0; i < NT; i++) stg[i] <= '0;
    end else begin
      run_q <= run_d;
      if (sel_mask) mask_q  <= wr_data[0];
      if (sel_pol)  pol_stg <= wr_data[3:0];
      for (int i = 0; i < NT; i++)
        if (wr_en && wr_addr == AW'(i + 4)) stg[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      for (int i = 0; i < NT; i++) cur[i] <= '0;
    end else if (!run_q || frame_last) begin
      pol_q <= pol_stg;
      for (int i = 0; i < NT; i++) cur[i] <= stg[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hseg_q <= S_SYNC;
      vseg_q <= S_SYNC;
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (!run_d) begin
      hseg_q <= S_SYNC;
      vseg_q <= S_SYNC;
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (run_q) begin
      if (h_end) begin
        hcnt_q <= '0;
        hseg_q <= hseg_q + 2'd1;
        if (hseg_q == S_FRONT) begin
          if (v_end) begin
            vcnt_q <= '0;
            vseg_q <= vseg_q + 2'd1;
          end else begin
            vcnt_q <= vcnt_q + 1'b1;
          end
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      stat_q <= 1'b0;
    else if (first_cyc)              stat_q <= 1'b1;
    else if (sel_stat && wr_data[0]) stat_q <= 1'b0;
  end

  wire h_raw  = run_q && hseg_q == S_SYNC;
  wire v_raw  = run_q && vseg_q == S_SYNC;
  wire h_act  = run_q && hseg_q == S_ACT;
  wire v_act  = run_q && vseg_q == S_ACT;

  assign hsync    = pol_q[0] ? h_raw : ~h_raw;
  assign vsync    = pol_q[1] ? v_raw : ~v_raw;
  assign de       = pol_q[2] ? (h_act && v_act) : ~(h_act && v_act);
  assign data_pol = pol_q[3];
  assign pix_x    = h_act ? hcnt_q : '0;
  assign pix_y    = v_act ? vcnt_q : '0;
  assign irq      = stat_q && mask_q;
endmodule

module vid_timing_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_q,
  input logic [W-1:0] hcnt_q,
  input logic [W-1:0] vcnt_q,
  input logic [W-1:0] hlen,
  input logic         first_cyc,
  input logic         frame_last,
  input logic         stat_q,
  input logic         mask_q,
  input logic         irq,
  input logic         de,
  input logic         de_pol,
  input logic [W-1:0] cur_hact
);
  // R5
  stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (hcnt_q == '0 && vcnt_q == '0));
  // R1
  hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt_q <= hlen);
  // R6
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(first_cyc));
  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q && stat_q));
  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(frame_last)) |-> $stable(cur_hact));
  // R3
  de_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de == de_pol) |-> run_q);
endmodule

bind vid_timing_gen vid_timing_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .hcnt_q(hcnt_q), .vcnt_q(vcnt_q),
  .hlen(hlen), .first_cyc(first_cyc), .frame_last(frame_last),
  .stat_q(stat_q), .mask_q(mask_q), .irq(irq), .de(de), .de_pol(pol_q[2]),
  .cur_hact(cur[2])
);

// File: tb/sim_vid_timing_gen.sv
module sim_vid_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic          hsync, vsync, de, data_pol, irq;
  logic [W-1:0]  pix_x, pix_y;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // model: staged and current geometry, position within frame
  int st[8];
  int cu[8];
  int st_pol = 0, cu_pol = 0;
  int hp = 0, ln = 0;

  vid_timing_gen #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
    .data_pol(data_pol), .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int seg(int p, int s, int b, int a);
    if (p < s) return 0;
    if (p < s + b) return 1;
    if (p < s + b + a) return 2;
    return 3;
  endfunction

  task automatic stage(int a, int d);
    if (a == 1) st_pol = d;
    if (a >= 4 && a <= 11) st[a-4] = d + 1;
  endtask

  task automatic prog(int a, int d);
    stage(a, d);
    wr(a, d);
  endtask

  task automatic start_model();
    for (int i = 0; i < 8; i++) cu[i] = st[i];
    cu_pol = st_pol; hp = 0; ln = 0;
  endtask

  // compare n cycles against the model; optional write issued at cycle upd
  task automatic span(string tag, int n, int upd, int ua, int ud);
    int e1 = 0, e2 = 0, e3 = 0, e4 = 0;
    for (int i = 0; i < n; i++) begin
      int hs = seg(hp, cu[0], cu[1], cu[2]);
      int vs = seg(ln, cu[4], cu[5], cu[6]);
      bit hr = (hs == 0), vr = (vs == 0), dr = (hs == 2 && vs == 2);
      int ex = (hs == 2) ? hp - cu[0] - cu[1] : 0;
      int ey = (vs == 2) ? ln - cu[4] - cu[5] : 0;
      if (hsync != (cu_pol[0] ? hr : !hr)) e1++;
      if (vsync != (cu_pol[1] ? vr : !vr)) e2++;
      if (de != (cu_pol[2] ? dr : !dr) || int'(pix_x) != ex || int'(pix_y) != ey) e3++;
      if (data_pol != cu_pol[3]) e4++;
      if (i == upd) begin
        wr_en = 1'b1; wr_addr = AW'(ua); wr_data = W'(ud); stage(ua, ud);
      end else wr_en = 1'b0;
      hp++;
      if (hp == cu[0] + cu[1] + cu[2] + cu[3]) begin
        hp = 0; ln++;
        if (ln == cu[4] + cu[5] + cu[6] + cu[7]) begin
          ln = 0;
          for (int k = 0; k < 8; k++) cu[k] = st[k];
          cu_pol = st_pol;
        end
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk({tag, " R1 hsync mismatches"}, e1, 0);
    chk({tag, " R2 vsync mismatches"}, e2, 0);
    chk({tag, " R3 de/coord mismatches"}, e3, 0);
    chk({tag, " R4 data_pol mismatches"}, e4, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R9: stopped, active-low idle => all strobes high
    chk("R9 hsync idle", hsync, 1);
    chk("R9 vsync idle", vsync, 1);
    chk("R9 de idle", de, 1);
    chk("R9 irq", irq, 0);
    chk("R9 data_pol", data_pol, 0);
    chk("R9 pix_x", int'(pix_x), 0);
  endtask

  task automatic t_frames_low();
    prog(4, 1); prog(5, 2); prog(6, 3); prog(7, 1);
    prog(8, 0); prog(9, 1); prog(10, 2); prog(11, 0);
    prog(1, 0);
    wr(0, 1);               // R5 start: now at first sync cycle
    start_model();
    span("low", 2 * 77 + 5, -1, 0, 0);
  endtask

  task automatic t_irq();
    wr(0, 0); wr(3, 1); wr(2, 1);
    @(negedge clk);
    chk("R6 irq with status clear", irq, 0);
    wr(0, 1);
    chk("R6 irq on first vsync clock", irq, 0);
    @(negedge clk);
    chk("R6 irq after first vsync clock", irq, 1);
    wr(3, 0);
    chk("R7 write 0 keeps status", irq, 1);
    wr(3, 1);
    chk("R7 write 1 clears status", irq, 0);
    wr(2, 0);
    repeat (80) @(negedge clk);
    chk("R6 masked irq", irq, 0);
    wr(2, 1);
    chk("R6 unmask shows latched status", irq, 1);
    wr(2, 0); wr(3, 1);
  endtask

  task automatic t_midframe();
    wr(0, 0);
    prog(1, 15);            // R8 applies at once while stopped
    @(negedge clk);
    chk("R4 data_pol high", data_pol, 1);
    chk("R4 hsync idle low", hsync, 0);
    wr(0, 1);
    start_model();
    span("pre", 20, 5, 6, 5);   // R8 active width change staged
    span("mid", 2 * 77 + 20, 3, 1, 0); // R8 polarity change staged
  endtask

  task automatic t_stop();
    wr(0, 0);
    // R5 stopped: strobes inactive (polarity 0 => high), coordinates 0
    for (int i = 0; i < 10; i++) begin
      if (i == 0 || i == 9) begin
        chk("R5 hsync stopped", hsync, 1);
        chk("R5 de stopped", de, 1);
        chk("R5 pix_x stopped", int'(pix_x), 0);
      end
      @(negedge clk);
    end
    wr(0, 1);
    start_model();
    span("restart", 77, -1, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin st[i] = 1; cu[i] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frames_low();
    t_irq();
    t_midframe();
    t_stop();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule